// File: doc/BRIEF.md
# Stepped Digital Gain Controller

This block steers the attenuation of a receiver's variable-gain stage while an OFDM packet's short preamble arrives. It watches the baseband I/Q pairs taken after that stage and keeps the largest squared envelope seen in each step interval. At the end of every interval it compares that peak against four levels placed around a target amplitude. It then raises or lowers the attenuation by a coarse or a fine amount, or holds it when the envelope already sits close enough to the target.

A one-cycle packet-start pulse loads a starting attenuation and latches the target. It also opens an adaptation window whose length, like the step interval, is given in clock cycles. When the window runs out the gain freezes on its own and a flag reports this. A separate freeze input holds the gain for as long as it is high. The attenuation is an unsigned count of dB of loss, so a value of N means a gain of -N dB. It never leaves the range 0 to 96.

Top module: `stepped_agc`

## Requirements
- R1: After reset, atten_db is 0, settled is 0 and frozen is 1. No decision is made, whatever the inputs, until the first pkt_start.
- R2: In the cycle after a pkt_start pulse, atten_db equals init_atten limited to 96, settled and frozen are 0, and target_amp has been latched for the whole packet.
- R3: Each decision uses the peak of I*I+Q*Q over the valid samples presented in the cycles after the previous decision point (or after pkt_start), up to and including the decision cycle. When there are no valid samples, the peak is 0.
- R4: With T = target_amp, the four levels are floor(T*T*K/256) with K = 809 (coarse high), 322 (fine high), 203 (fine low) and 81 (coarse low). High levels are crossed only when the peak is strictly greater than them, and low levels only when it is strictly less.
- R5: When the peak is above the coarse-high level, atten_db rises by 5. Otherwise, above the fine-high level it rises by 1. Otherwise, below the coarse-low level it falls by 5, and below the fine-low level it falls by 1.
- R6: A peak inside the dead band (none of the four conditions true) leaves atten_db unchanged and sets settled. Settled then stays set until the next pkt_start.
- R7: atten_db saturates at 96 on the way up and at 0 on the way down, and never wraps.
- R8: With S = step_cycles (at least 1), decisions happen only in the S-th, 2S-th, ... cycle after the pkt_start cycle. atten_db is constant in all other cycles.
- R9: freeze high in a decision cycle cancels that decision: no attenuation change and no settled update. The decision schedule and the peak restart are unaffected.
- R10: With W = window_cycles (at least 1), only decision cycles at or before the W-th cycle after pkt_start count. frozen reads 1 from the cycle after that, and atten_db then holds until the next pkt_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_start | input | 1 | One-cycle pulse that opens a packet's adaptation window |
| freeze | input | 1 | Holds the gain while high |
| in_valid | input | 1 | The I/Q pair on this cycle is a sample |
| in_i | input | SAMPLE_W | In-phase sample, two's complement |
| in_q | input | SAMPLE_W | Quadrature sample, two's complement |
| target_amp | input | SAMPLE_W | Target envelope amplitude, unsigned |
| init_atten | input | ATTEN_W | Attenuation loaded at packet start, in dB |
| step_cycles | input | CNT_W | Clock cycles per decision step |
| window_cycles | input | CNT_W | Clock cycles in the adaptation window |
| atten_db | output | ATTEN_W | Current attenuation in dB |
| settled | output | 1 | A dead-band decision has been seen in this packet |
| frozen | output | 1 | The adaptation window has ended |

## Verification
The bench aims at exact threshold equality. With a target of 16, a sample of (28,5) lands on the coarse-high level and (9,0) lands on the coarse-low level. A design that compared with the wrong inclusiveness would take a 5 dB step instead of a 1 dB step. It also drives attenuation into both rails and loads an out-of-range starting value, which a design without saturation would wrap. Freeze asserted across decision points and windows as short as three cycles with a one-cycle step catch a design that lets one extra decision slip through, or that moves the schedule. Random packets with gapped samples and restarts in mid-packet expose a peak detector that misses a sample or keeps stale history.

// File: rtl/stepped_agc_pkg.sv
// Package: shared constants and types for the stepped gain controller.
// Assumes: threshold scale factors are in units of 1/256.
package stepped_agc_pkg;

    // Gain action chosen at one decision point.
    typedef enum logic [2:0] {
        ACT_HOLD = 3'd0,
        ACT_UP1  = 3'd1,
        ACT_UP5  = 3'd2,
        ACT_DN1  = 3'd3,
        ACT_DN5  = 3'd4
    } gain_act_e;

    localparam int unsigned SCALE_SHIFT = 8;
    localparam int unsigned K_W         = 10;
    localparam int unsigned NUM_LEVELS  = 4;

    // Level index: 0 coarse high, 1 fine high, 2 fine low, 3 coarse low.
    localparam int unsigned LVL_K [NUM_LEVELS] = '{809, 322, 203, 81};

    localparam int unsigned COARSE_DB = 5;
    localparam int unsigned FINE_DB   = 1;

endpackage

// File: rtl/agc_envelope.sv
// Module: agc_envelope
// Squares each valid I/Q pair and keeps the peak since the last step point.
// peak_now includes the sample of the current cycle, so a decision made in
// this cycle sees it. Assumes clr and tick are single-cycle events.
module agc_envelope #(
    parameter int SAMPLE_W = 12,
    localparam int SQ_W    = 2 * SAMPLE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       tick,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_i,
    input  logic signed [SAMPLE_W-1:0] in_q,
    output logic        [SQ_W-1:0]     peak_now
);

    logic signed [SQ_W-1:0] ii_sq;
    logic signed [SQ_W-1:0] qq_sq;
    logic        [SQ_W-1:0] mag_sq;
    logic        [SQ_W-1:0] peak_q;

    // Squared magnitude of the current pair and peak including it.
    always_comb begin
        ii_sq    = in_i * in_i;
        qq_sq    = in_q * in_q;
        mag_sq   = SQ_W'(ii_sq) + SQ_W'(qq_sq);
        peak_now = (in_valid && (mag_sq > peak_q)) ? mag_sq : peak_q;
    end

    // Peak register, restarted at each step point and at packet start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) begin
            peak_q <= '0;
        end else begin
            peak_q <= peak_now;
        end
    end

    // R3: between restarts the held peak can only grow.
    p_peak_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> (peak_q >= $past(peak_q)));

endmodule

// File: rtl/agc_thresh.sv
// Module: agc_thresh
// Derives the four comparison levels from the target amplitude and latches
// them at packet start, so the multipliers sit off the per-sample path.
// Assumes target_amp is valid in the pkt_start cycle.
module agc_thresh
    import stepped_agc_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    localparam int TSQ_W   = 2 * SAMPLE_W,
    localparam int PROD_W  = TSQ_W + K_W,
    localparam int TH_W    = PROD_W - SCALE_SHIFT
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load,
    input  logic [SAMPLE_W-1:0]              target_amp,
    output logic [NUM_LEVELS-1:0][TH_W-1:0]  levels
);

    logic [TSQ_W-1:0] tsq;

    // Target amplitude squared.
    always_comb begin
        tsq = TSQ_W'(target_amp) * TSQ_W'(target_amp);
    end

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
        logic [PROD_W-1:0] prod;

        // Scaled target power for this level.
        always_comb begin
            prod = PROD_W'(tsq) * PROD_W'(LVL_K[g]);
        end

        // Latch the level at packet start.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                levels[g] <= '0;
            end else if (load) begin
                levels[g] <= prod[PROD_W-1:SCALE_SHIFT];
            end
        end
    end

    // R4: the levels keep their order high to low once latched.
    p_level_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (levels[0] >= levels[1]) && (levels[1] >= levels[2]) && (levels[2] >= levels[3]));

endmodule

// File: rtl/agc_timer.sv
// Module: agc_timer
// Generates the step point and the adaptation window. The step counter and the
// window counter restart on start and stop once the window has expired.
// Assumes step_cycles and window_cycles are at least 1 and do not change mid-packet.
module agc_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             freeze,
    input  logic [CNT_W-1:0] step_cycles,
    input  logic [CNT_W-1:0] window_cycles,
    output logic             tick,
    output logic             step_en,
    output logic             frozen
);

    logic [CNT_W-1:0] step_cnt_q;
    logic [CNT_W-1:0] win_cnt_q;
    logic             frozen_q;

    // Step point and the decision enable it yields when not held.
    always_comb begin
        tick    = !frozen_q && !start && (step_cnt_q == (step_cycles - CNT_W'(1)));
        step_en = tick && !freeze;
        frozen  = frozen_q;
    end

    // Step and window counting with automatic freeze at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_cnt_q <= '0;
            win_cnt_q  <= '0;
            frozen_q   <= 1'b1;
        end else if (start) begin
            step_cnt_q <= '0;
            win_cnt_q  <= '0;
            frozen_q   <= 1'b0;
        end else if (!frozen_q) begin
            step_cnt_q <= tick ? '0 : step_cnt_q + CNT_W'(1);
            win_cnt_q  <= win_cnt_q + CNT_W'(1);
            if (win_cnt_q == (window_cycles - CNT_W'(1))) begin
                frozen_q <= 1'b1;
            end
        end
    end

    // R10: once frozen, only a new packet reopens the window.
    p_frozen_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_q && !start) |=> frozen_q);

    // R8: no step point two cycles running unless the step is one cycle long.
    p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (step_cycles != CNT_W'(1)) && $stable(step_cycles)) |=> !tick);

endmodule

// File: rtl/agc_gain.sv
// Module: agc_gain
// Chooses the gain action from the peak and the levels, applies it with
// saturation, and tracks the settled flag. Assumes step_en is one cycle wide.
module agc_gain
    import stepped_agc_pkg::*;
#(
    parameter int SQ_W      = 24,
    parameter int TH_W      = 26,
    parameter int ATTEN_W   = 7,
    parameter int MAX_ATTEN = 96
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load,
    input  logic [ATTEN_W-1:0]              init_atten,
    input  logic                            step_en,
    input  logic [SQ_W-1:0]                 peak,
    input  logic [NUM_LEVELS-1:0][TH_W-1:0] levels,
    output logic [ATTEN_W-1:0]              atten,
    output logic                            settled
);

    localparam logic [ATTEN_W-1:0] MAX_A    = ATTEN_W'(MAX_ATTEN);
    localparam logic [ATTEN_W-1:0] COARSE_A = ATTEN_W'(COARSE_DB);
    localparam logic [ATTEN_W-1:0] FINE_A   = ATTEN_W'(FINE_DB);

    logic [TH_W-1:0]    peak_ext;
    gain_act_e          act;
    logic [ATTEN_W-1:0] atten_nx;
    logic [ATTEN_W-1:0] atten_q;
    logic               settled_q;

    // Pick the action: coarse checks first, dead band last.
    always_comb begin
        peak_ext = TH_W'(peak);
        if (peak_ext > levels[0]) begin
            act = ACT_UP5;
        end else if (peak_ext > levels[1]) begin
            act = ACT_UP1;
        end else if (peak_ext < levels[3]) begin
            act = ACT_DN5;
        end else if (peak_ext < levels[2]) begin
            act = ACT_DN1;
        end else begin
            act = ACT_HOLD;
        end
    end

    // Apply the action with saturation at both rails.
    always_comb begin
        unique case (act)
            ACT_UP5: atten_nx = (atten_q > MAX_A - COARSE_A) ? MAX_A : atten_q + COARSE_A;
            ACT_UP1: atten_nx = (atten_q > MAX_A - FINE_A)   ? MAX_A : atten_q + FINE_A;
            ACT_DN5: atten_nx = (atten_q < COARSE_A) ? '0 : atten_q - COARSE_A;
            ACT_DN1: atten_nx = (atten_q < FINE_A)   ? '0 : atten_q - FINE_A;
            default: atten_nx = atten_q;
        endcase
    end

    // Attenuation and settled state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            atten_q   <= '0;
            settled_q <= 1'b0;
        end else if (load) begin
            atten_q   <= (init_atten > MAX_A) ? MAX_A : init_atten;
            settled_q <= 1'b0;
        end else if (step_en) begin
            atten_q <= atten_nx;
            if (act == ACT_HOLD) begin
                settled_q <= 1'b1;
            end
        end
    end

    assign atten   = atten_q;
    assign settled = settled_q;

    // R7: attenuation never leaves its range.
    p_atten_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        atten_q <= MAX_A);

    // R8: attenuation moves only at a decision or a load.
    p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_en) |=> $stable(atten_q));

    // R5: one decision moves attenuation by at most the coarse step.
    p_step_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load) |=>
        (((atten_q >= $past(atten_q)) ? (atten_q - $past(atten_q))
                                      : ($past(atten_q) - atten_q)) <= COARSE_A));

    // R6: settled stays set until the next load.
    p_settled_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (settled_q && !load) |=> settled_q);

endmodule

// File: rtl/stepped_agc.sv
// Module: stepped_agc
// Top level of the stepped gain controller: envelope peak, threshold levels,
// step and window timing, and the gain decision. Assumes pkt_start is a
// one-cycle pulse and the configuration inputs are stable within a packet.
module stepped_agc
    import stepped_agc_pkg::*;
#(
    parameter int SAMPLE_W  = 12,
    parameter int ATTEN_W   = 7,
    parameter int MAX_ATTEN = 96,
    parameter int CNT_W     = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pkt_start,
    input  logic                       freeze,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_i,
    input  logic signed [SAMPLE_W-1:0] in_q,
    input  logic [SAMPLE_W-1:0]        target_amp,
    input  logic [ATTEN_W-1:0]         init_atten,
    input  logic [CNT_W-1:0]           step_cycles,
    input  logic [CNT_W-1:0]           window_cycles,
    output logic [ATTEN_W-1:0]         atten_db,
    output logic                       settled,
    output logic                       frozen
);

    localparam int SQ_W = 2 * SAMPLE_W;
    localparam int TH_W = SQ_W + K_W - SCALE_SHIFT;

    logic                            tick;
    logic                            step_en;
    logic [SQ_W-1:0]                 peak_now;
    logic [NUM_LEVELS-1:0][TH_W-1:0] levels;

    agc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (pkt_start),
        .freeze        (freeze),
        .step_cycles   (step_cycles),
        .window_cycles (window_cycles),
        .tick          (tick),
        .step_en       (step_en),
        .frozen        (frozen)
    );

    agc_envelope #(.SAMPLE_W(SAMPLE_W)) u_env (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pkt_start),
        .tick     (tick),
        .in_valid (in_valid),
        .in_i     (in_i),
        .in_q     (in_q),
        .peak_now (peak_now)
    );

    agc_thresh #(.SAMPLE_W(SAMPLE_W)) u_thresh (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pkt_start),
        .target_amp (target_amp),
        .levels     (levels)
    );

    agc_gain #(
        .SQ_W      (SQ_W),
        .TH_W      (TH_W),
        .ATTEN_W   (ATTEN_W),
        .MAX_ATTEN (MAX_ATTEN)
    ) u_gain (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pkt_start),
        .init_atten (init_atten),
        .step_en    (step_en),
        .peak       (peak_now),
        .levels     (levels),
        .atten      (atten_db),
        .settled    (settled)
    );

    // R9: a held gain does not move unless a new packet starts.
    p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !pkt_start) |=> $stable(atten_db));

    // R10: after the window ends the gain does not move.
    p_window_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !pkt_start) |=> $stable(atten_db));

    // R1: before the first packet after reset nothing adapts.
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !pkt_start) |=> !$rose(settled));

endmodule

// File: tb/stepped_agc_test.sv
module stepped_agc_test;

    localparam int SAMPLE_W = 12;
    localparam int ATTEN_W  = 7;
    localparam int CNT_W    = 16;
    localparam int MAXA     = 96;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       pkt_start = 1'b0;
    logic                       freeze = 1'b0;
    logic                       in_valid = 1'b0;
    logic signed [SAMPLE_W-1:0] in_i = '0;
    logic signed [SAMPLE_W-1:0] in_q = '0;
    logic [SAMPLE_W-1:0]        target_amp = '0;
    logic [ATTEN_W-1:0]         init_atten = '0;
    logic [CNT_W-1:0]           step_cycles = 16'd1;
    logic [CNT_W-1:0]           window_cycles = 16'd1;
    logic [ATTEN_W-1:0]         atten_db;
    logic                       settled;
    logic                       frozen;

    int n_checks = 0;
    int n_errors = 0;
    string cur_req = "R1";

    // Reference state, built from the requirements.
    int    m_atten = 0;
    int    m_set   = 0;
    int    m_frz   = 1;
    int    m_step  = 0;
    int    m_win   = 0;
    longint m_peak = 0;
    longint m_lvl [4] = '{0, 0, 0, 0};
    int    cfg_t = 0;
    int    cfg_s = 1;
    int    cfg_w = 1;
    int    cfg_init = 0;

    always #4 clk = ~clk;

    stepped_agc uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pkt_start     (pkt_start),
        .freeze        (freeze),
        .in_valid      (in_valid),
        .in_i          (in_i),
        .in_q          (in_q),
        .target_amp    (target_amp),
        .init_atten    (init_atten),
        .step_cycles   (step_cycles),
        .window_cycles (window_cycles),
        .atten_db      (atten_db),
        .settled       (settled),
        .frozen        (frozen)
    );

    function automatic int lvl_k(input int idx);
        case (idx)
            0: return 809;
            1: return 322;
            2: return 203;
            default: return 81;
        endcase
    endfunction

    // Next reference state for one cycle of stimulus.
    function automatic void model_step(input bit st, input bit fz, input bit vl,
                                       input int si, input int sq_q);
        longint sq;
        longint pk;
        bit tk;
        sq = longint'(si) * si + longint'(sq_q) * sq_q;
        if (st) begin
            m_atten = (cfg_init > MAXA) ? MAXA : cfg_init;
            m_set = 0; m_frz = 0; m_step = 0; m_win = 0; m_peak = 0;
            for (int k = 0; k < 4; k++)
                m_lvl[k] = (longint'(cfg_t) * cfg_t * lvl_k(k)) >>> 8;
        end else begin
            tk = (m_frz == 0) && (m_step == cfg_s - 1);
            pk = (vl && sq > m_peak) ? sq : m_peak;
            if (tk && !fz) begin
                if (pk > m_lvl[0])      m_atten = (m_atten + 5 > MAXA) ? MAXA : m_atten + 5;
                else if (pk > m_lvl[1]) m_atten = (m_atten + 1 > MAXA) ? MAXA : m_atten + 1;
                else if (pk < m_lvl[3]) m_atten = (m_atten < 5) ? 0 : m_atten - 5;
                else if (pk < m_lvl[2]) m_atten = (m_atten < 1) ? 0 : m_atten - 1;
                else m_set = 1;
            end
            m_peak = tk ? 0 : pk;
            if (m_frz == 0) begin
                m_step = tk ? 0 : m_step + 1;
                if (m_win == cfg_w - 1) m_frz = 1;
                m_win = m_win + 1;
            end
        end
    endfunction

    task automatic check_out();
        n_checks++;
        if (atten_db !== ATTEN_W'(m_atten) || settled !== m_set[0] || frozen !== m_frz[0]) begin
            n_errors++;
            $display("FAIL %s atten=%0d exp %0d settled=%0b exp %0b frozen=%0b exp %0b",
                     cur_req, atten_db, m_atten, settled, m_set[0], frozen, m_frz[0]);
        end
    endtask

    task automatic expect_lit(input int ea, input int es, input int ef, input string req);
        n_checks++;
        if (atten_db !== ATTEN_W'(ea) || settled !== es[0] || frozen !== ef[0]) begin
            n_errors++;
            $display("FAIL %s atten=%0d exp %0d settled=%0b exp %0b frozen=%0b exp %0b",
                     req, atten_db, ea, settled, es[0], frozen, ef[0]);
        end
    endtask

    // One clock cycle: check the state, then drive this cycle's inputs.
    task automatic cycle(input bit fz, input bit vl, input int si, input int sq_q);
        @(negedge clk);
        check_out();
        pkt_start = 1'b0;
        freeze    = fz;
        in_valid  = vl;
        in_i      = SAMPLE_W'(si);
        in_q      = SAMPLE_W'(sq_q);
        model_step(1'b0, fz, vl, si, sq_q);
    endtask

    task automatic start_pkt(input int t, input int init, input int s, input int w);
        @(negedge clk);
        check_out();
        cfg_t = t; cfg_init = init; cfg_s = s; cfg_w = w;
        target_amp    = SAMPLE_W'(t);
        init_atten    = ATTEN_W'(init);
        step_cycles   = CNT_W'(s);
        window_cycles = CNT_W'(w);
        pkt_start = 1'b1;
        freeze    = 1'b0;
        in_valid  = 1'b0;
        in_i      = '0;
        in_q      = '0;
        model_step(1'b1, 1'b0, 1'b0, 0, 0);
    endtask

    task automatic repeat_cycles(input int n, input bit fz, input bit vl, input int si, input int sq_q);
        for (int k = 0; k < n; k++) cycle(fz, vl, si, sq_q);
    endtask

    function automatic int rnd_signed(input int a);
        int v;
        v = int'($urandom_range(0, 2 * a)) - a;
        if (v > 2047) v = 2047;
        if (v < -2048) v = -2048;
        return v;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));

        // R1: reset state and no adaptation before the first packet.
        cur_req = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_lit(0, 0, 1, "R1");
        rst_n = 1'b1;
        repeat_cycles(12, 1'b0, 1'b1, 2000, 0);
        @(negedge clk);
        expect_lit(0, 0, 1, "R1");

        // R4: peak equal to the coarse-high level takes the fine step.
        cur_req = "R4";
        start_pkt(16, 50, 4, 40);
        repeat_cycles(45, 1'b0, 1'b1, 28, 5);
        expect_lit(60, 0, 1, "R4");
        // R4: peak equal to the coarse-low level takes the fine step down.
        start_pkt(16, 50, 4, 40);
        repeat_cycles(45, 1'b0, 1'b1, 9, 0);
        expect_lit(40, 0, 1, "R4");

        // R7: saturation at the top rail; R2: out-of-range start value.
        cur_req = "R7";
        start_pkt(16, 94, 2, 20);
        repeat_cycles(24, 1'b0, 1'b1, 2000, 0);
        expect_lit(96, 0, 1, "R7");
        cur_req = "R2";
        start_pkt(16, 120, 4, 20);
        cycle(1'b0, 1'b1, 2000, 0);
        expect_lit(96, 0, 0, "R2");
        repeat_cycles(3, 1'b0, 1'b1, 16, 0);

        // R7: saturation at the bottom rail with no valid samples.
        cur_req = "R7";
        start_pkt(16, 3, 3, 30);
        repeat_cycles(34, 1'b0, 1'b0, 0, 0);
        expect_lit(0, 0, 1, "R7");

        // R6: dead band sets settled, which survives later moves.
        cur_req = "R6";
        start_pkt(16, 30, 5, 50);
        repeat_cycles(10, 1'b0, 1'b1, 16, 0);
        repeat_cycles(45, 1'b0, 1'b1, 2000, 0);
        expect_lit(70, 1, 1, "R6");

        // R9: freeze across decision points holds the gain.
        cur_req = "R9";
        start_pkt(16, 40, 4, 200);
        repeat_cycles(40, 1'b1, 1'b1, 2000, 0);
        cycle(1'b0, 1'b1, 2000, 0);
        expect_lit(40, 0, 0, "R9");
        repeat_cycles(8, 1'b0, 1'b1, 2000, 0);
        expect_lit(50, 0, 0, "R9");

        // R10: short window with a one-cycle step.
        cur_req = "R10";
        start_pkt(16, 0, 1, 3);
        repeat_cycles(20, 1'b0, 1'b1, 2000, 0);
        expect_lit(15, 0, 1, "R10");

        // R3 R5 R8: random packets, gapped samples, freeze and restarts.
        cur_req = "R3 R5 R8";
        for (int p = 0; p < 80; p++) begin
            int t;
            int len;
            t = int'($urandom_range(4, 1000));
            start_pkt(t, int'($urandom_range(0, 127)), int'($urandom_range(1, 8)),
                      int'($urandom_range(1, 80)));
            len = cfg_w + int'($urandom_range(0, 10));
            for (int k = 0; k < len; k++) begin
                int amp;
                amp = (t * int'($urandom_range(0, 40))) / 16;
                cycle(($urandom_range(0, 9) == 0), ($urandom_range(0, 3) != 0),
                      rnd_signed(amp), rnd_signed(amp / 2));
                if ($urandom_range(0, 199) == 0) break;
            end
        end
        @(negedge clk);
        check_out();

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule